// File: doc/BRIEF.md
# Bipolar Receive Line Formatter

This block sits behind the slicer of a T1/E1 line receiver. It takes the two already-sliced receive rails and the recovered clock. A positive mark raises `pos_in` and a negative mark raises `neg_in`. It presents the line data on two outputs in one of two formats.

In bipolar mode both rails pass through to `rx_p` and `rx_n` unchanged. In NRZ mode the marks merge onto `rx_p`, and `rx_n` carries a one-period error strobe instead. The strobe fires for:
- a double mark;
- a same-polarity mark that no zero-substitution code explains;
- an over-long run of zeros.

`t1_mode` selects the line standard. In T1 mode the 8-zero substitution sequence is accepted and the zero limit is 16. In E1 mode the 4-zero substitution violations are accepted and the zero limit is 4.

A substitution checker state machine follows each accepted T1 violation through the rest of its sequence. Its states are:
- `CK_RUN`: normal alternate-mark checking.
- `CK_SUB_B1`: expects an opposite-polarity mark.
- `CK_SUB_Z`: expects a zero.
- `CK_SUB_V2`: expects a second same-polarity mark.
- `CK_SUB_B2`: expects a closing opposite mark.

It moves through these states as follows:
- From `CK_RUN` it goes to `CK_SUB_B1` on a T1 violation that follows exactly three zeros.
- Each `CK_SUB_*` state advances to the next state when the expected symbol arrives.
- `CK_SUB_B2` returns to `CK_RUN` when the expected symbol arrives.
- Any unexpected symbol in a `CK_SUB_*` state raises the strobe and returns to `CK_RUN`.

`edge_sel` picks the receive clock edge on which the outputs change.

Top module: `rx_line_formatter`

## Requirements
- R1: With `nrz_mode`=0, `rx_p` and `rx_n` repeat `pos_in` and `neg_in` of each bit period unchanged, including a bit with both rails high.
- R2: With `nrz_mode`=1, `rx_p` carries `pos_in` OR `neg_in` of each bit period.
- R3: With `nrz_mode`=1, `rx_n` is high for exactly one bit period for each erroneous bit and low otherwise. A bit with both rails high is erroneous. So is a mark whose polarity equals that of the previous mark, unless R6 or R7 excuses it.
- R4: The first mark after reset is never a violation, whatever its polarity. A double mark does not change the remembered polarity.
- R5: Counting consecutive zero bits since the last mark, the error strobe fires on the 16th zero in T1 mode (`t1_mode`=1) and on the 4th zero in E1 mode (`t1_mode`=0). It fires once per run, however long the run lasts.
- R6: In T1 mode, a same-polarity mark preceded by exactly 3 zeros starts a substitution check. The following bits must be: an opposite mark, a zero, a mark of the same polarity as the one before it, and an opposite mark. A complete sequence raises no error. The first bit that departs from it raises one error.
- R7: In E1 mode, a same-polarity mark preceded by 2 or 3 zeros is accepted. With any other number of preceding zeros it is an error.
- R8: With `edge_sel`=0, the outputs for the bit sampled at a rising edge of `rclk` change at that same rising edge. With `edge_sel`=1, they change at the following falling edge and hold their previous value until then.
- R9: A synchronous reset clears the polarity memory, the zero count and the checker state, and drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous reset, active high |
| pos_in | input | 1 | Sliced positive-mark rail |
| neg_in | input | 1 | Sliced negative-mark rail |
| nrz_mode | input | 1 | 0 = bipolar pass-through, 1 = merged data with error strobe |
| t1_mode | input | 1 | 1 = T1 rules, 0 = E1 rules |
| edge_sel | input | 1 | 0 = outputs change on rising edge, 1 = on falling edge |
| rx_p | output | 1 | Positive rail or merged NRZ data |
| rx_n | output | 1 | Negative rail or error strobe |

## Verification
The bench builds the block with its default zero limits of 16 for T1 and 4 for E1. This keeps both excess-zero events within a few dozen bits. It also lets a single zero run show saturation and the absence of a repeated strobe. With a limit of 4 in E1, the three-zero and two-zero substitution forms sit just under the limit. This checks that the limit and the substitution rules do not interfere. Separate phases cover T1 and E1 in NRZ mode, bipolar pass-through, and the falling-edge output. The falling-edge phase is observed both before and after the falling edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // substitution checker states
    typedef enum logic [2:0] {
        CK_RUN    = 3'd0,
        CK_SUB_B1 = 3'd1,
        CK_SUB_Z  = 3'd2,
        CK_SUB_V2 = 3'd3,
        CK_SUB_B2 = 3'd4
    } ck_state_e;

    // zeros preceding an accepted violation
    localparam int T1_SUB_LEAD   = 3;
    localparam int E1_SUB_LEAD_A = 2;
    localparam int E1_SUB_LEAD_B = 3;

endpackage

// File: rtl/rxf_zero_run.sv
module rxf_zero_run #(
    parameter int T1_LIMIT = 16,
    parameter int E1_LIMIT = 4,
    parameter int W        = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         t1_mode,
    input  logic         mark_any,
    output logic [W-1:0] zrun,
    output logic         exz
);
    localparam logic [W-1:0] T1_L = W'(T1_LIMIT);
    localparam logic [W-1:0] E1_L = W'(E1_LIMIT);

    logic [W-1:0] lim;

    always_comb begin
        lim = t1_mode ? T1_L : E1_L;
        exz = !mark_any && (zrun == lim - W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun <= '0;
        end else if (mark_any) begin
            zrun <= '0;
        end else if (zrun < lim) begin
            zrun <= zrun + W'(1);
        end
    end

    // one strobe per run
    assert_exz_once_R5: assert property (@(posedge clk) disable iff (rst)
        exz |=> !exz);

    assert_zrun_bound_R5: assert property (@(posedge clk) disable iff (rst)
        zrun <= T1_L);

endmodule

// File: rtl/rxf_code_check.sv
module rxf_code_check
    import rxf_pkg::*;
#(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         t1_mode,
    input  logic         pos,
    input  logic         neg,
    input  logic [W-1:0] zrun,
    output logic         viol
);
    localparam logic [W-1:0] T1_LEAD = W'(T1_SUB_LEAD);
    localparam logic [W-1:0] E1_LA   = W'(E1_SUB_LEAD_A);
    localparam logic [W-1:0] E1_LB   = W'(E1_SUB_LEAD_B);

    ck_state_e st, st_nxt;
    logic      last_neg;
    logic      have_mark;
    logic      mark, dbl, zero, same, bpv;

    always_comb begin
        mark = pos ^ neg;
        dbl  = pos & neg;
        zero = !pos && !neg;
        same = mark && (neg == last_neg);
        bpv  = same && have_mark;
    end

    // state and polarity register
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= CK_RUN;
            last_neg  <= 1'b0;
            have_mark <= 1'b0;
        end else begin
            st <= st_nxt;
            if (mark) begin
                last_neg  <= neg;
                have_mark <= 1'b1;
            end
        end
    end

    // next state and violation output
    always_comb begin
        st_nxt = st;
        viol   = 1'b0;
        unique case (st)
            CK_RUN: begin
                if (dbl) begin
                    viol = 1'b1;
                end else if (bpv) begin
                    if (t1_mode) begin
                        if (zrun == T1_LEAD) st_nxt = CK_SUB_B1;
                        else                 viol   = 1'b1;
                    end else if (!(zrun == E1_LA || zrun == E1_LB)) begin
                        viol = 1'b1;
                    end
                end
            end
            CK_SUB_B1: begin
                if (mark && !same) st_nxt = CK_SUB_Z;
                else begin viol = 1'b1; st_nxt = CK_RUN; end
            end
            CK_SUB_Z: begin
                if (zero) st_nxt = CK_SUB_V2;
                else begin viol = 1'b1; st_nxt = CK_RUN; end
            end
            CK_SUB_V2: begin
                if (same) st_nxt = CK_SUB_B2;
                else begin viol = 1'b1; st_nxt = CK_RUN; end
            end
            CK_SUB_B2: begin
                if (mark && !same) st_nxt = CK_RUN;
                else begin viol = 1'b1; st_nxt = CK_RUN; end
            end
            default: st_nxt = CK_RUN;
        endcase
    end

    // a substitution check only opens after a single-rail mark
    assert_sub_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (st == CK_SUB_B1) |-> $past(pos ^ neg));

endmodule

// File: rtl/rxf_edge_out.sv
module rxf_edge_out (
    input  logic clk,
    input  logic rst,
    input  logic edge_sel,
    input  logic d_p,
    input  logic d_n,
    output logic out_p,
    output logic out_n
);
    logic rise_p, rise_n, fall_p, fall_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_p <= 1'b0;
            rise_n <= 1'b0;
        end else begin
            rise_p <= d_p;
            rise_n <= d_n;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            fall_p <= 1'b0;
            fall_n <= 1'b0;
        end else begin
            fall_p <= rise_p;
            fall_n <= rise_n;
        end
    end

    always_comb begin
        out_p = edge_sel ? fall_p : rise_p;
        out_n = edge_sel ? fall_n : rise_n;
    end

    assert_reset_low_R9: assert property (@(posedge clk)
        rst |=> (!rise_p && !rise_n));

endmodule

// File: rtl/rx_line_formatter.sv
module rx_line_formatter #(
    parameter int T1_ZERO_LIMIT = 16,
    parameter int E1_ZERO_LIMIT = 4
) (
    input  logic rclk,
    input  logic rst,
    input  logic pos_in,
    input  logic neg_in,
    input  logic nrz_mode,
    input  logic t1_mode,
    input  logic edge_sel,
    output logic rx_p,
    output logic rx_n
);
    localparam int ZMAX = (T1_ZERO_LIMIT > E1_ZERO_LIMIT) ? T1_ZERO_LIMIT : E1_ZERO_LIMIT;
    localparam int ZW   = $clog2(ZMAX + 1);

    logic [ZW-1:0] zrun;
    logic          exz, viol, err;
    logic          d_p, d_n;

    rxf_zero_run #(
        .T1_LIMIT (T1_ZERO_LIMIT),
        .E1_LIMIT (E1_ZERO_LIMIT),
        .W        (ZW)
    ) u_zero (
        .clk      (rclk),
        .rst      (rst),
        .t1_mode  (t1_mode),
        .mark_any (pos_in | neg_in),
        .zrun     (zrun),
        .exz      (exz)
    );

    rxf_code_check #(
        .W (ZW)
    ) u_check (
        .clk     (rclk),
        .rst     (rst),
        .t1_mode (t1_mode),
        .pos     (pos_in),
        .neg     (neg_in),
        .zrun    (zrun),
        .viol    (viol)
    );

    always_comb begin
        err = viol | exz;
        d_p = nrz_mode ? (pos_in | neg_in) : pos_in;
        d_n = nrz_mode ? err : neg_in;
    end

    rxf_edge_out u_out (
        .clk      (rclk),
        .rst      (rst),
        .edge_sel (edge_sel),
        .d_p      (d_p),
        .d_n      (d_n),
        .out_p    (rx_p),
        .out_n    (rx_n)
    );

    assert_bipolar_pass_R1: assert property (@(posedge rclk) disable iff (rst)
        !nrz_mode |=> (edge_sel || (rx_p == $past(pos_in) && rx_n == $past(neg_in))));

    assert_nrz_merge_R2: assert property (@(posedge rclk) disable iff (rst)
        nrz_mode |=> (edge_sel || rx_p == $past(pos_in | neg_in)));

endmodule

// File: tb/rx_line_formatter_test.sv
module rx_line_formatter_test;

    typedef struct packed {
        int   due;
        logic p;
        logic n;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pos_in = 1'b0, neg_in = 1'b0;
    logic nrz_mode = 1'b0, t1_mode = 1'b0, edge_sel = 1'b0;
    logic rx_p, rx_n;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    item_t q[$];
    string tags[$];
    item_t prev;

    rx_line_formatter uut (
        .rclk     (clk),
        .rst      (rst),
        .pos_in   (pos_in),
        .neg_in   (neg_in),
        .nrz_mode (nrz_mode),
        .t1_mode  (t1_mode),
        .edge_sel (edge_sel),
        .rx_p     (rx_p),
        .rx_n     (rx_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input logic ap, input logic an, input logic ep, input logic en,
                         input string tag);
        checks++;
        if (ap !== ep || an !== en) begin
            fails++;
            $display("FAIL %s: rx_p/rx_n actual %b%b expected %b%b at cycle %0d",
                     tag, ap, an, ep, en, cyc);
        end
    endtask

    // monitor: pops expected items when their bit comes out
    initial begin
        prev = '0;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0 && q[0].due == cyc) begin
                if (edge_sel) check(rx_p, rx_n, prev.p, prev.n, {tags[0], " R8 hold"});
                else          check(rx_p, rx_n, q[0].p, q[0].n, {tags[0], " R8 rise"});
                #5;
                check(rx_p, rx_n, q[0].p, q[0].n, tags[0]);
                prev = q.pop_front();
                void'(tags.pop_front());
            end
        end
    end

    task automatic send(input logic p, input logic n, input logic e, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        pos_in = p;
        neg_in = n;
        it.due = cyc + 1;
        it.p   = nrz_mode ? (p | n) : p;
        it.n   = nrz_mode ? e : n;
        q.push_back(it);
        tags.push_back(tag);
    endtask

    task automatic do_reset(input logic t1, input logic nrz, input logic es);
        wait (q.size() == 0);
        @(posedge clk);
        #1;
        rst = 1'b1; pos_in = 1'b0; neg_in = 1'b0;
        t1_mode = t1; nrz_mode = nrz; edge_sel = es;
        @(posedge clk);
        #1;
        rst = 1'b0;
        #6;
        check(rx_p, rx_n, 1'b0, 1'b0, "R9 reset");
        prev = '0;
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // T1, NRZ, rising edge
        do_reset(1'b1, 1'b1, 1'b0);
        send(0, 1, 0, "R4 first mark");
        send(1, 0, 0, "R2");
        send(0, 1, 0, "R2");
        send(0, 1, 1, "R3 bpv");
        send(1, 0, 0, "R3");
        for (int i = 0; i < 3; i++) send(0, 0, 0, "R6 lead");
        send(1, 0, 0, "R6 V1");
        send(0, 1, 0, "R6 B1");
        send(0, 0, 0, "R6 Z");
        send(0, 1, 0, "R6 V2");
        send(1, 0, 0, "R6 B2");
        send(0, 1, 0, "R6 after");
        for (int i = 0; i < 3; i++) send(0, 0, 0, "R6 lead");
        send(0, 1, 0, "R6 V1");
        send(0, 1, 1, "R6 broken");
        send(1, 0, 0, "R6 recover");
        for (int i = 0; i < 16; i++) send(0, 0, (i == 15), "R5 t1 run");
        send(0, 0, 0, "R5 no repeat");
        send(0, 0, 0, "R5 no repeat");
        send(0, 1, 0, "R5 end");

        // E1, NRZ, rising edge
        do_reset(1'b0, 1'b1, 1'b0);
        send(1, 0, 0, "R4 first mark");
        send(0, 1, 0, "R2");
        send(1, 0, 0, "R2");
        for (int i = 0; i < 3; i++) send(0, 0, 0, "R7 lead3");
        send(1, 0, 0, "R7 V after 3");
        send(0, 1, 0, "R7");
        send(1, 0, 0, "R7 B");
        send(0, 0, 0, "R7 lead2");
        send(0, 0, 0, "R7 lead2");
        send(1, 0, 0, "R7 V after 2");
        send(0, 1, 0, "R7");
        send(0, 0, 0, "R7 lead1");
        send(0, 1, 1, "R7 V after 1");
        send(1, 0, 0, "R3");
        send(1, 0, 1, "R3 bpv");
        for (int i = 0; i < 4; i++) send(0, 0, (i == 3), "R5 e1 run");
        send(0, 0, 0, "R5 no repeat");
        send(1, 1, 1, "R3 double");
        send(0, 1, 0, "R4 double keeps polarity");

        // bipolar pass-through
        do_reset(1'b1, 1'b0, 1'b0);
        send(1, 0, 0, "R1");
        send(0, 1, 0, "R1");
        send(1, 1, 0, "R1 both");
        send(0, 0, 0, "R1");
        send(0, 1, 0, "R1");
        send(0, 1, 0, "R1 bpv passes");

        // falling-edge output
        do_reset(1'b0, 1'b1, 1'b1);
        send(1, 0, 0, "R8 fall");
        send(1, 0, 1, "R8 fall bpv");
        send(0, 0, 0, "R8 fall");
        send(0, 0, 0, "R8 fall");
        send(0, 1, 0, "R8 fall");
        send(1, 1, 1, "R8 fall double");
        send(1, 0, 0, "R8 fall");

        wait (q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule